// File: doc/BRIEF.md
# Sawtooth Piecewise-Linear Nonlinearity Evaluator

This block evaluates the sawtooth-shaped nonlinearity that drives the state update of a multi-scroll chaotic oscillator. A signed fixed-point sample `x_in` enters with a valid strobe. A fixed number of clocks later, the block returns `f(x)` with its own strobe. The number of scrolls, the breakpoint positions, the common slope and the outer amplitude are all elaboration-time parameters. Only the sample changes at run time.

For `NSCROLL` scrolls there are `NSCROLL-1` ascending breakpoints, which split the input axis into `NSCROLL` segments that share one slope. The two outer segments are anchored at the first and last breakpoint and shifted down or up by the amplitude. Each inner segment is centred on the midpoint of its own breakpoint pair, so the output falls back at every breakpoint instead of levelling off. A row of parallel comparators picks the segment, and three registered arithmetic stages follow. The result is a 4-cycle pipeline that accepts one sample per clock.

Numbers use two's complement with `FRAC` fractional bits. The sample and the result are `W` bits wide, and the slope is `MW` bits wide with the same number of fractional bits.

Top module: `sawtooth_pwl_eval`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `f_out` are 0, including when reset is applied in the middle of traffic.
- R2: If x < B0 (the first breakpoint), the result is slope*(x − B0) − K.
- R3: If x ≥ B_last (the last breakpoint), the result is slope*(x − B_last) + K.
- R4: If Bj ≤ x < Bj+1 for adjacent breakpoints, the result is slope*(x − mid). Here mid = floor((Bj + Bj+1)/2).
- R5: A sample exactly equal to a breakpoint is evaluated with the segment to the right of that breakpoint.
- R6: A sample accepted at a rising edge with `in_valid` high appears on `f_out` with `out_valid` high exactly 4 rising edges later. `out_valid` is low in the cycle before. Samples on consecutive cycles produce results on consecutive cycles.
- R7: When no result is emerging, `out_valid` is low and `f_out` keeps its last value. `x_in` is ignored while `in_valid` is low.
- R8: The product of slope and offset is shifted right by `FRAC` bits with rounding toward negative infinity. After the ±K offset is added, the sum saturates to the signed `W`-bit range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `x_in` for this cycle |
| x_in | input | W | Signed fixed-point sample |
| out_valid | output | 1 | Marks a new result on `f_out` |
| f_out | output | W | Signed fixed-point f(x), saturated |

## Verification
A wrong segment choice at the comparators shows up four cycles later as a result that is off by a whole multiple of the amplitude, or by slope times half a segment width. The clearest cases are samples on a breakpoint and one LSB below it. A valid pipeline that drops or duplicates a bit shows up in the same cycle the result is due, as a strobe that is missing, early or doubled. A stage that loads while idle shows up as `f_out` changing during cycles with no valid result. Rounding or saturation faults appear only at odd products and at the extreme input codes, so those codes are driven explicitly.

// File: rtl/sawpwl_pkg.sv
package sawpwl_pkg;

  // floor of the mean of two breakpoints
  function automatic longint midpoint(input longint lo, input longint hi);
    return (lo + hi) >>> 1;
  endfunction

endpackage

// File: rtl/sawpwl_region.sv
module sawpwl_region #(
  parameter int W    = 16,
  parameter int NBRK = 3,
  parameter int RW   = 2,
  parameter logic [NBRK*W-1:0] BRK = '0
) (
  input  logic signed [W-1:0] x,
  output logic [RW-1:0]       region
);

  logic [NBRK-1:0] ge;

  for (genvar j = 0; j < NBRK; j++) begin : g_cmp
    assign ge[j] = (x >= $signed(BRK[j*W +: W]));
  end

  // outer segments have priority, then the inner pair that brackets x
  always_comb begin
    region = '0;
    if (!ge[0]) begin
      region = '0;
    end else if (ge[NBRK-1]) begin
      region = RW'(NBRK);
    end else begin
      for (int j = 0; j < NBRK-1; j++) begin
        if (ge[j] && !ge[j+1]) region = RW'(j+1);
      end
    end
  end

endmodule

// File: rtl/sawpwl_ref.sv
module sawpwl_ref #(
  parameter int W    = 16,
  parameter int NBRK = 3,
  parameter int RW   = 2,
  parameter logic [NBRK*W-1:0] BRK = '0,
  parameter logic signed [W-1:0] AMP = '0
) (
  input  logic [RW-1:0]       region,
  output logic signed [W-1:0] anchor,
  output logic signed [W-1:0] offset
);

  logic signed [W-1:0] anchor_tab [NBRK+1];

  for (genvar r = 0; r <= NBRK; r++) begin : g_tab
    if (r == 0) begin : g_left
      assign anchor_tab[r] = $signed(BRK[W-1:0]);
    end else if (r == NBRK) begin : g_right
      assign anchor_tab[r] = $signed(BRK[NBRK*W-1 -: W]);
    end else begin : g_mid
      localparam longint LO = longint'($signed(BRK[(r-1)*W +: W]));
      localparam longint HI = longint'($signed(BRK[r*W +: W]));
      assign anchor_tab[r] = W'(sawpwl_pkg::midpoint(LO, HI));
    end
  end

  always_comb begin
    anchor = anchor_tab[region];
    if (region == '0)             offset = -AMP;
    else if (region == RW'(NBRK)) offset = AMP;
    else                          offset = '0;
  end

endmodule

// File: rtl/sawpwl_sat.sv
module sawpwl_sat #(
  parameter int IW = 34,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);

  localparam logic signed [IW-1:0] MAXV = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW-1:0] MINV = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  always_comb begin
    if (din > MAXV)      dout = MAXV[OW-1:0];
    else if (din < MINV) dout = MINV[OW-1:0];
    else                 dout = din[OW-1:0];
  end

endmodule

// File: rtl/sawtooth_pwl_eval.sv
module sawtooth_pwl_eval #(
  parameter int W       = 16,
  parameter int FRAC    = 10,
  parameter int MW      = 16,
  parameter int NSCROLL = 4,
  parameter logic [(NSCROLL-1)*W-1:0] BRK = {16'sd2048, 16'sd0, -16'sd2048},
  parameter logic signed [MW-1:0] SLOPE = 16'sd1536,
  parameter logic signed [W-1:0]  AMP   = 16'sd1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] x_in,
  output logic                out_valid,
  output logic signed [W-1:0] f_out
);

  localparam int NBRK = NSCROLL - 1;
  localparam int RW   = $clog2(NBRK + 1);
  localparam int DW   = W + 1;
  localparam int PW   = DW + MW;
  localparam int SW   = PW + 1;
  localparam logic signed [W-1:0] B_FIRST = $signed(BRK[W-1:0]);
  localparam logic signed [W-1:0] B_LAST  = $signed(BRK[NBRK*W-1 -: W]);

  // stage 1: region select
  logic                s1_valid;
  logic signed [W-1:0] s1_x, s1_x_d;
  logic [RW-1:0]       s1_region, s1_region_d;
  // stage 2: offset from anchor
  logic                s2_valid;
  logic signed [DW-1:0] s2_diff, s2_diff_d;
  logic signed [W-1:0]  s2_off, s2_off_d;
  // stage 3: scaled product
  logic                 s3_valid;
  logic signed [PW-1:0] s3_prod, s3_prod_d;
  logic signed [W-1:0]  s3_off, s3_off_d;
  // stage 4: result
  logic signed [W-1:0]  f_d;

  logic signed [W-1:0]  anchor, offset;
  logic [RW-1:0]        region;
  logic signed [PW-1:0] prod_full;
  logic signed [SW-1:0] sum;

  sawpwl_region #(.W(W), .NBRK(NBRK), .RW(RW), .BRK(BRK)) u_region (
    .x      (x_in),
    .region (region)
  );

  sawpwl_ref #(.W(W), .NBRK(NBRK), .RW(RW), .BRK(BRK), .AMP(AMP)) u_ref (
    .region (s1_region),
    .anchor (anchor),
    .offset (offset)
  );

  sawpwl_sat #(.IW(SW), .OW(W)) u_sat (
    .din  (sum),
    .dout (f_d)
  );

  always_comb begin
    s1_x_d      = x_in;
    s1_region_d = region;
    s2_diff_d   = DW'(s1_x) - DW'(anchor);
    s2_off_d    = offset;
    prod_full   = $signed({{MW{s2_diff[DW-1]}}, s2_diff}) *
                  $signed({{DW{SLOPE[MW-1]}}, SLOPE});
    s3_prod_d   = prod_full >>> FRAC;
    s3_off_d    = s2_off;
    sum         = SW'(s3_prod) + SW'(s3_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s2_valid  <= 1'b0;
      s3_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s2_valid  <= s1_valid;
      s3_valid  <= s2_valid;
      out_valid <= s3_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_x      <= '0;
      s1_region <= '0;
      s2_diff   <= '0;
      s2_off    <= '0;
      s3_prod   <= '0;
      s3_off    <= '0;
      f_out     <= '0;
    end else begin
      if (in_valid) begin
        s1_x      <= s1_x_d;
        s1_region <= s1_region_d;
      end
      if (s1_valid) begin
        s2_diff <= s2_diff_d;
        s2_off  <= s2_off_d;
      end
      if (s2_valid) begin
        s3_prod <= s3_prod_d;
        s3_off  <= s3_off_d;
      end
      if (s3_valid) f_out <= f_d;
    end
  end

  // R2: left outer segment only for samples below the first breakpoint
  p_left_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_region == '0) |-> (s1_x < B_FIRST));

  // R3: right outer segment only at or above the last breakpoint
  p_right_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_region == RW'(NBRK)) |-> (s1_x >= B_LAST));

  // R5: a sample sitting on the first breakpoint never goes left
  p_tie_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_x == B_FIRST) |-> (s1_region != '0));

  // R6: a result strobe always follows a valid third stage
  p_valid_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s3_valid));

  // R7: output data holds unless a result is being loaded
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s3_valid |=> $stable(f_out));

endmodule

// File: tb/sim_sawtooth_pwl_eval.sv
module sim_sawtooth_pwl_eval;

  localparam int W = 16;
  localparam int FRAC = 10;
  localparam longint M = 1536;
  localparam longint K = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [W-1:0] x_in;
  logic out_valid;
  logic signed [W-1:0] f_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sawtooth_pwl_eval #(
    .W(16), .FRAC(10), .MW(16), .NSCROLL(4),
    .BRK({16'sd2048, 16'sd0, -16'sd2048}),
    .SLOPE(16'sd1536), .AMP(16'sd1024)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
    .out_valid(out_valid), .f_out(f_out)
  );

  function automatic longint model(input longint x);
    longint b [3];
    longint v;
    b[0] = -2048; b[1] = 0; b[2] = 2048;
    if (x < b[0])       v = ((M * (x - b[0])) >>> FRAC) - K;
    else if (x >= b[2]) v = ((M * (x - b[2])) >>> FRAC) + K;
    else begin
      v = 0;
      for (int j = 0; j < 2; j++)
        if (x >= b[j] && x < b[j+1])
          v = (M * (x - ((b[j] + b[j+1]) >>> 1))) >>> FRAC;
    end
    if (v > 32767)  v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one isolated sample, checked at the exact result cycle
  task automatic single(input string req, input longint x);
    @(negedge clk);
    in_valid = 1'b1; x_in = W'(x);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk({req, " early strobe (R6)"}, longint'(out_valid), 0);
    @(negedge clk);
    chk({req, " strobe (R6)"}, longint'(out_valid), 1);
    chk(req, longint'(f_out), model(x));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; x_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", longint'(out_valid), 0);
    chk("R1 f_out in reset", longint'(f_out), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_left;
    single("R2 far left", -5000);
    single("R2 one below B0, R8 floor", -2049);
  endtask

  task automatic t_right;
    single("R3 right", 3001);
    single("R3 right small", 2100);
  endtask

  task automatic t_inner;
    single("R4 inner low", -1500);
    single("R4 inner high", 777);
    single("R4 just below B2", 2047);
  endtask

  task automatic t_ties;
    single("R5 tie B0", -2048);
    single("R5 tie B1", 0);
    single("R5 tie B2", 2048);
  endtask

  task automatic t_sat;
    single("R8 saturate high", 32767);
    single("R8 saturate low", -32768);
    single("R8 odd product", -3);
  endtask

  task automatic t_stream;
    longint xs [6];
    xs[0] = -4000; xs[1] = -2048; xs[2] = -1; xs[3] = 0; xs[4] = 2047; xs[5] = 9000;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        chk("R6 back-to-back strobe", longint'(out_valid), 1);
        chk("R6 back-to-back data", longint'(f_out), model(xs[i-4]));
      end
      if (i < 6) begin
        in_valid = 1'b1; x_in = W'(xs[i]);
      end else in_valid = 1'b0;
    end
  endtask

  task automatic t_hold;
    longint held;
    single("R7 setup", 1234);
    held = model(1234);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      x_in = W'(-30000 + i * 9000);
      chk("R7 idle strobe", longint'(out_valid), 0);
      chk("R7 held data", longint'(f_out), held);
    end
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    in_valid = 1'b1; x_in = 16'sd3000;
    @(negedge clk);
    x_in = 16'sd500;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    chk("R1 mid-run out_valid", longint'(out_valid), 0);
    chk("R1 mid-run f_out", longint'(f_out), 0);
    repeat (5) @(negedge clk);
    chk("R1 flushed out_valid", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_left;
    t_right;
    t_inner;
    t_ties;
    t_sat;
    t_stream;
    t_hold;
    t_reset_mid;
    single("R4 after reset", -700);
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

endmodule